// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block sits between a serial receiver and a serial transmitter and carries out software flow control. Each received character is compared with the programmed start and stop characters. A stop match holds the transmitter off, and a later start match lets it run again. Characters that match are taken out of the receive stream. Every other character is passed on to the receive FIFO one cycle later. Matching works in one of two modes: one character at a time, or a pair of consecutive characters in a fixed order. Only the low bits that the programmed word length selects take part in a comparison.

The block also watches the receive FIFO fill level. When the level reaches the trigger level, it offers the stop character or stop pair to the transmitter. When the level drops below the trigger level, it offers the start character or start pair. These offers go out through a valid/ready port and are never raised while a character is on the line. A special-character mode is also provided. In this mode every character is compared with the second stop register, and a match is still stored in the FIFO. The match sets a sticky flag, and an interrupt is raised when it is enabled.

Top module: `swfc_top`

## Requirements
- R1: After reset all four flow-control character registers hold zero, so the first injected stop and start characters are 0x00. A write with `cfg_sel` 0/1/2/3 loads start-1/start-2/stop-1/stop-2.
- R2: In single mode with flow enabled, a received character equal to stop-1 sets `flow_stopped` in the next cycle and is not written to the FIFO.
- R3: `tx_pause` rises only in a cycle after `tx_busy` was sampled low, so a character already being sent completes. It falls one cycle after `flow_stopped` falls.
- R4: A received character equal to start-1 clears `flow_stopped` and is not written to the FIFO.
- R5: In pair mode, stop-1 followed by stop-2 sets `flow_stopped`, and start-1 followed by start-2 clears it. Neither character of a matched pair reaches the FIFO.
- R6: In pair mode, a valid first character followed by a wrong second character resets the detector. The first character is written to the FIFO one cycle after the second is received, the second character is written one cycle later, and `flow_stopped` does not change.
- R7: `word_len` values 0/1/2/3 select 5/6/7/8 compared bits. Bit 0 of each register lines up with bit 0 of the character, and higher bits are ignored.
- R8: In special mode, each character is compared with stop-2 alone and every character is written to the FIFO. A match sets `special_seen`, which stays set until `flag_clr`, and `flow_stopped` does not change.
- R9: `irq` equals (`irq_en[0]` and `flow_stopped`) or (`irq_en[1]` and `special_seen`).
- R10: When `rx_level` goes from below `trig_level` to at or above it, `inj_valid` rises in the next cycle with stop-1 on `inj_data`. In pair mode, stop-2 follows once the first character has been accepted.
- R11: When `rx_level` falls below `trig_level`, start-1 (then start-2 in pair mode) is offered. Each crossing produces exactly one offer sequence.
- R12: `inj_valid` is low whenever `tx_busy` is high.
- R13: With flow control disabled, or for non-matching characters, each received character appears on `fifo_wr`/`fifo_data` in the cycle after `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the character registers |
| cfg_sel | input | 2 | Register select: 0 start-1, 1 start-2, 2 stop-1, 3 stop-2 |
| cfg_wdata | input | 8 | Register write data |
| flow_en | input | 1 | Enables software flow control matching and injection |
| dual_mode | input | 1 | 1 = two-character sequences |
| special_mode | input | 1 | 1 = special-character flagging instead of flow matching |
| word_len | input | 2 | Compared width: 5 + value bits |
| irq_en | input | 2 | bit0 flow-stop interrupt, bit1 special-character interrupt |
| flag_clr | input | 1 | Clears `special_seen` |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| fifo_wr | output | 1 | Write strobe to receive FIFO |
| fifo_data | output | 8 | Character to receive FIFO |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| trig_level | input | LVL_W | Receive trigger level |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_pause | output | 1 | Transmitter must not start a FIFO character |
| inj_valid | output | 1 | Flow character offered to the transmitter |
| inj_data | output | 8 | Offered flow character |
| inj_ready | input | 1 | Transmitter takes the offered character |
| flow_stopped | output | 1 | Remote stop received, transmission suspended |
| special_seen | output | 1 | Sticky special-character match flag |
| irq | output | 1 | Interrupt request |

## Verification
A sequence detector stuck in its first-match state shows up at the next received character. Either a legitimate character goes missing from `fifo_wr`, or `flow_stopped` flips without a full pair having arrived. A wrong threshold-side register shows up one cycle after `rx_level` crosses: `inj_valid` comes out missing, repeated or carrying the wrong character. A pause register that ignores `tx_busy` rises while a character is in flight and is caught in that same cycle.

// File: rtl/swfc_pkg.sv
// Shared definitions for the software flow controller.
// Assumes 8-bit characters on every character path.
package swfc_pkg;
    localparam int CHAR_W = 8;
    localparam int NREG   = 4;

    typedef enum logic [1:0] {
        SEL_ON1  = 2'd0,
        SEL_ON2  = 2'd1,
        SEL_OFF1 = 2'd2,
        SEL_OFF2 = 2'd3
    } xsel_e;

    typedef logic [CHAR_W-1:0] char_t;

    // Bit mask for the programmed word length (5..8 bits)
    function automatic char_t len_mask(input logic [1:0] wl);
        case (wl)
            2'd0:    len_mask = char_t'(8'h1F);
            2'd1:    len_mask = char_t'(8'h3F);
            2'd2:    len_mask = char_t'(8'h7F);
            default: len_mask = char_t'(8'hFF);
        endcase
    endfunction

    // Masked equality of a received character and a register
    function automatic logic ch_eq(input char_t a, input char_t b, input char_t m);
        ch_eq = ((a ^ b) & m) == '0;
    endfunction
endpackage

// File: rtl/swfc_regs.sv
// Holds the four flow-control characters (start-1/2, stop-1/2).
// Assumes one write per cycle; all entries clear to zero on reset.
module swfc_regs
    import swfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  sel,
    input  char_t       wdata,
    output char_t       on1,
    output char_t       on2,
    output char_t       off1,
    output char_t       off2
);
    char_t bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Load entry i when selected, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank[i] <= '0;
            else if (we && sel == 2'(i))
                bank[i] <= wdata;
        end
    end

    assign on1  = bank[SEL_ON1];
    assign on2  = bank[SEL_ON2];
    assign off1 = bank[SEL_OFF1];
    assign off2 = bank[SEL_OFF2];
endmodule

// File: rtl/swfc_match.sv
// Receive-side matcher: filters start/stop characters, tracks the
// suspended state, handles pair sequences and special-character mode.
// Assumes rx_valid is never high in two consecutive cycles (a serial
// receiver delivers characters many cycles apart), which leaves a free
// cycle for the second write after a broken pair.
module swfc_match
    import swfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        dual,
    input  logic        special,
    input  logic [1:0]  wlen,
    input  logic        clr,
    input  char_t       on1,
    input  char_t       on2,
    input  char_t       off1,
    input  char_t       off2,
    input  logic        rx_valid,
    input  char_t       rx_data,
    output logic        wr,
    output char_t       wdata,
    output logic        stopped,
    output logic        spec_flag
);
    char_t mask;
    char_t hold_data;
    char_t pend_data;
    logic  hold_vld;
    logic  hold_off;
    logic  pend_vld;
    char_t want2;

    assign mask  = len_mask(wlen);
    assign want2 = hold_off ? off2 : on2;

    // Character classification, FIFO delivery and suspend-state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr        <= 1'b0;
            wdata     <= '0;
            stopped   <= 1'b0;
            spec_flag <= 1'b0;
            hold_vld  <= 1'b0;
            hold_off  <= 1'b0;
            hold_data <= '0;
            pend_vld  <= 1'b0;
            pend_data <= '0;
        end else begin
            wr <= 1'b0;
            if (clr)
                spec_flag <= 1'b0;
            if (pend_vld) begin
                wr       <= 1'b1;
                wdata    <= pend_data;
                pend_vld <= 1'b0;
            end
            if (!en || special) begin
                stopped  <= 1'b0;
                hold_vld <= 1'b0;
            end
            if (rx_valid) begin
                if (special) begin
                    wr    <= 1'b1;
                    wdata <= rx_data;
                    if (ch_eq(rx_data, off2, mask))
                        spec_flag <= 1'b1;
                end else if (!en) begin
                    wr    <= 1'b1;
                    wdata <= rx_data;
                end else if (!dual) begin
                    if (ch_eq(rx_data, off1, mask))
                        stopped <= 1'b1;
                    else if (ch_eq(rx_data, on1, mask))
                        stopped <= 1'b0;
                    else begin
                        wr    <= 1'b1;
                        wdata <= rx_data;
                    end
                end else if (hold_vld) begin
                    hold_vld <= 1'b0;
                    if (ch_eq(rx_data, want2, mask))
                        stopped <= hold_off;
                    else begin
                        wr        <= 1'b1;
                        wdata     <= hold_data;
                        pend_vld  <= 1'b1;
                        pend_data <= rx_data;
                    end
                end else if (ch_eq(rx_data, off1, mask)) begin
                    hold_vld  <= 1'b1;
                    hold_off  <= 1'b1;
                    hold_data <= rx_data;
                end else if (ch_eq(rx_data, on1, mask)) begin
                    hold_vld  <= 1'b1;
                    hold_off  <= 1'b0;
                    hold_data <= rx_data;
                end else begin
                    wr    <= 1'b1;
                    wdata <= rx_data;
                end
            end
        end
    end
endmodule

// File: rtl/swfc_inject.sv
// Transmit-side injector: watches the receive FIFO level against the
// trigger level and queues one stop or start sequence per crossing.
// Assumes the transmitter only accepts (inj_ready) between characters.
module swfc_inject
    import swfc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dual,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    input  char_t            on1,
    input  char_t            on2,
    input  char_t            off1,
    input  char_t            off2,
    input  logic             tx_busy,
    input  logic             ready,
    output logic             valid,
    output char_t            data
);
    logic       above;
    logic       lvl_hi;
    logic [1:0] left;
    logic       idx;
    logic       kind_off;

    assign lvl_hi = level >= trig;
    assign valid  = (left != 2'd0) && !tx_busy;
    assign data   = kind_off ? (idx ? off2 : off1) : (idx ? on2 : on1);

    // Track the threshold side and step through the queued sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            above    <= 1'b0;
            left     <= 2'd0;
            idx      <= 1'b0;
            kind_off <= 1'b0;
        end else begin
            above <= lvl_hi;
            if (!en) begin
                left <= 2'd0;
            end else if (lvl_hi != above) begin
                left     <= dual ? 2'd2 : 2'd1;
                idx      <= 1'b0;
                kind_off <= lvl_hi;
            end else if (valid && ready) begin
                left <= left - 2'd1;
                idx  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/swfc_top.sv
// Software flow controller top: character registers, receive matcher,
// level-driven injector, transmit pause gating and interrupt output.
// Assumes a transmitter that samples tx_pause before starting a FIFO
// character and raises tx_busy for the whole character time.
module swfc_top
    import swfc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic             flow_en,
    input  logic             dual_mode,
    input  logic             special_mode,
    input  logic [1:0]       word_len,
    input  logic [1:0]       irq_en,
    input  logic             flag_clr,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             fifo_wr,
    output logic [7:0]       fifo_data,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] trig_level,
    input  logic             tx_busy,
    output logic             tx_pause,
    output logic             inj_valid,
    output logic [7:0]       inj_data,
    input  logic             inj_ready,
    output logic             flow_stopped,
    output logic             special_seen,
    output logic             irq
);
    char_t on1, on2, off1, off2;

    swfc_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .on1   (on1),
        .on2   (on2),
        .off1  (off1),
        .off2  (off2)
    );

    swfc_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (flow_en),
        .dual      (dual_mode),
        .special   (special_mode),
        .wlen      (word_len),
        .clr       (flag_clr),
        .on1       (on1),
        .on2       (on2),
        .off1      (off1),
        .off2      (off2),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .wr        (fifo_wr),
        .wdata     (fifo_data),
        .stopped   (flow_stopped),
        .spec_flag (special_seen)
    );

    swfc_inject #(.LVL_W(LVL_W)) u_inject (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (flow_en),
        .dual    (dual_mode),
        .level   (rx_level),
        .trig    (trig_level),
        .on1     (on1),
        .on2     (on2),
        .off1    (off1),
        .off2    (off2),
        .tx_busy (tx_busy),
        .ready   (inj_ready),
        .valid   (inj_valid),
        .data    (inj_data)
    );

    // Pause the transmitter only once the character in flight has ended
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_pause <= 1'b0;
        else if (!flow_stopped)
            tx_pause <= 1'b0;
        else if (!tx_busy)
            tx_pause <= 1'b1;
    end

    assign irq = (irq_en[0] && flow_stopped) || (irq_en[1] && special_seen);
endmodule

// File: rtl/swfc_chk.sv
// Property checker for swfc_top, attached by bind below.
module swfc_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic fifo_wr,
    input logic tx_busy,
    input logic tx_pause,
    input logic inj_valid,
    input logic flow_stopped,
    input logic special_seen,
    input logic irq
);
    a_r3_pause_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> !$past(tx_busy));

    a_r3_pause_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> flow_stopped);

    a_r12_no_inject_busy: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !tx_busy);

    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flow_stopped || special_seen));

    a_r13_write_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_wr) |-> $past(rx_valid));
endmodule

bind swfc_top swfc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .fifo_wr      (fifo_wr),
    .tx_busy      (tx_busy),
    .tx_pause     (tx_pause),
    .inj_valid    (inj_valid),
    .flow_stopped (flow_stopped),
    .special_seen (special_seen),
    .irq          (irq)
);

// File: tb/swfc_top_tb_top.sv
// Directed bench for swfc_top: one task per scenario.
module swfc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       flow_en = 1'b1;
    logic       dual_mode = 1'b0;
    logic       special_mode = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic [1:0] irq_en = 2'd0;
    logic       flag_clr = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic [7:0] rx_level = 8'd0;
    logic [7:0] trig_level = 8'd200;
    logic       tx_busy = 1'b0;
    logic       tx_pause;
    logic       inj_valid;
    logic [7:0] inj_data;
    logic       inj_ready = 1'b0;
    logic       flow_stopped;
    logic       special_seen;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    swfc_top dut_i (.*);

    // Compare one observed value with its expected value
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one character; returns at the negedge after the capturing edge
    task automatic send(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset_values;
        chk("R1 reset fifo_wr", fifo_wr, 0);
        chk("R1 reset stopped", flow_stopped, 0);
        trig_level = 8'd1;
        @(negedge clk); rx_level = 8'd1;
        @(negedge clk);
        chk("R1 zero stop char valid", inj_valid, 1);
        chk("R1 zero stop char", inj_data, 8'h00);
        inj_ready = 1'b1; @(negedge clk); inj_ready = 1'b0;
        rx_level = 8'd0;
        @(negedge clk);
        chk("R1 zero start char", inj_data, 8'h00);
        inj_ready = 1'b1; @(negedge clk); inj_ready = 1'b0;
        trig_level = 8'd200;
        repeat (2) @(negedge clk);
        wr_reg(2'd0, 8'h11); wr_reg(2'd1, 8'h12);
        wr_reg(2'd2, 8'h13); wr_reg(2'd3, 8'h14);
    endtask

    task automatic t_single;
        send(8'h41);
        chk("R13 pass char wr", fifo_wr, 1);
        chk("R13 pass char data", fifo_data, 8'h41);
        tx_busy = 1'b1;
        send(8'h13);
        chk("R2 stop filtered", fifo_wr, 0);
        chk("R2 stopped", flow_stopped, 1);
        repeat (3) @(negedge clk);
        chk("R3 no pause while busy", tx_pause, 0);
        tx_busy = 1'b0;
        @(negedge clk);
        chk("R3 pause after char", tx_pause, 1);
        irq_en = 2'b01;
        #1 chk("R9 irq on stop", irq, 1);
        irq_en = 2'b00;
        #1 chk("R9 irq masked", irq, 0);
        send(8'h11);
        chk("R4 start filtered", fifo_wr, 0);
        chk("R4 resumed", flow_stopped, 0);
        @(negedge clk);
        chk("R3 pause released", tx_pause, 0);
    endtask

    task automatic t_mask;
        word_len = 2'd0;
        send(8'hF3);
        chk("R7 masked stop match", flow_stopped, 1);
        chk("R7 masked filtered", fifo_wr, 0);
        send(8'hE0 | 8'h11);
        chk("R7 masked start match", flow_stopped, 0);
        word_len = 2'd3;
        send(8'hF3);
        chk("R7 8bit no match", flow_stopped, 0);
        chk("R7 8bit passed", fifo_data, 8'hF3);
    endtask

    task automatic t_dual;
        dual_mode = 1'b1;
        send(8'h13);
        chk("R5 first held", fifo_wr, 0);
        chk("R5 not yet stopped", flow_stopped, 0);
        send(8'h14);
        chk("R5 pair stop", flow_stopped, 1);
        chk("R5 pair filtered", fifo_wr, 0);
        send(8'h11);
        send(8'h55);
        chk("R6 still stopped", flow_stopped, 1);
        chk("R6 held char out", fifo_data, 8'h11);
        chk("R6 held wr", fifo_wr, 1);
        @(negedge clk);
        chk("R6 second wr", fifo_wr, 1);
        chk("R6 second data", fifo_data, 8'h55);
        send(8'h11);
        send(8'h12);
        chk("R5 pair start", flow_stopped, 0);
        chk("R5 start filtered", fifo_wr, 0);
        dual_mode = 1'b0;
    endtask

    task automatic t_special;
        special_mode = 1'b1;
        send(8'h14);
        chk("R8 stored", fifo_wr, 1);
        chk("R8 data", fifo_data, 8'h14);
        chk("R8 flag", special_seen, 1);
        chk("R8 no stop", flow_stopped, 0);
        send(8'h13);
        chk("R8 stop1 stored", fifo_data, 8'h13);
        chk("R8 stop1 no stop", flow_stopped, 0);
        irq_en = 2'b10;
        #1 chk("R9 irq special", irq, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R8 flag cleared", special_seen, 0);
        chk("R9 irq cleared", irq, 0);
        irq_en = 2'b00;
        special_mode = 1'b0;
    endtask

    task automatic t_inject;
        trig_level = 8'd4;
        dual_mode = 1'b1;
        @(negedge clk); rx_level = 8'd4;
        @(negedge clk);
        chk("R10 stop offered", inj_valid, 1);
        chk("R10 stop1 data", inj_data, 8'h13);
        tx_busy = 1'b1;
        #1 chk("R12 hidden while busy", inj_valid, 0);
        @(negedge clk); tx_busy = 1'b0;
        inj_ready = 1'b1;
        @(negedge clk);
        chk("R10 stop2 data", inj_data, 8'h14);
        @(negedge clk); inj_ready = 1'b0;
        chk("R10 sequence done", inj_valid, 0);
        rx_level = 8'd6;
        repeat (3) @(negedge clk);
        chk("R11 once per crossing", inj_valid, 0);
        dual_mode = 1'b0;
        rx_level = 8'd3;
        @(negedge clk);
        chk("R11 start offered", inj_valid, 1);
        chk("R11 start1 data", inj_data, 8'h11);
        inj_ready = 1'b1;
        @(negedge clk); inj_ready = 1'b0;
        chk("R11 single done", inj_valid, 0);
    endtask

    task automatic t_disabled;
        flow_en = 1'b0;
        send(8'h13);
        chk("R13 disabled passes stop", fifo_wr, 1);
        chk("R13 disabled data", fifo_data, 8'h13);
        chk("R13 disabled no stop", flow_stopped, 0);
        flow_en = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_single();
        t_mask();
        t_dual();
        t_special();
        t_inject();
        t_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule